// File: doc/BRIEF.md
# Three-Plane Coincidence Road Trigger

This block raises a fast trigger for a particle detector built from four hodoscope planes, each divided into 32 paddles. A track crossing the detector fires one paddle per plane. The block compares the live hit pattern against a list of roads that is fixed when the design is built. A road names exactly three of the four planes and one paddle in each. When every paddle of some road is hit, the trigger output goes high.

The path from the four hit vectors to the trigger bit has no clock stage, so the decision arrives within a few gate delays and fits a budget well under 40 ns. The road matches are merged through a balanced OR tree, so the logic depth grows with the logarithm of the road count and the list can grow to thousands of entries. A separate registered stage captures the trigger and the per-road match vector on each rising clock edge for downstream logic that needs stable values. Each road's paddle indices are checked against the paddle count while the design is being built.

Top module: `road_matcher`

## Requirements
- R1: The block takes four hit vectors of 32 bits each, `plane0_hits` to `plane3_hits`. Bit i of a vector is paddle i of that plane, and paddle 31 is usable like any other.
- R2: A road matches only when all three paddles it names are hit at the same time in their own planes. If any one of the three is not hit, the road does not match.
- R3: Road k takes bits [17k+16 : 17k] of the `ROAD_TABLE` parameter. Bits [16:15] of an entry give the number of the plane the road skips (0 to 3). The other three planes take the index fields in ascending plane order: bits [14:10] for the lowest of them, bits [9:5] for the middle one and bits [4:0] for the highest.
- R4: `trig` is the OR of all road matches. It is low whenever no road matches, including when every hit input is zero.
- R5: `trig` follows the hit inputs combinationally: it settles after an input change without any clock edge.
- R6: On every rising edge of `clk` while reset is released, `trig_q` and `match_q` take the values that `trig` and the road matches had just before that edge.
- R7: Pulling `rst_n` low clears `trig_q` and `match_q` at once, without waiting for a clock edge, and holds them at zero while reset stays low.
- R8: A hit in a road's skipped plane, or on a paddle the road does not name, has no effect on that road's match.
- R9: Bit k of `match_q` belongs to road k. `trig_q` is high exactly when at least one bit of `match_q` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the registered output stage |
| rst_n | input | 1 | Asynchronous reset, active low |
| plane0_hits | input | 32 | Paddle hits of plane 0 |
| plane1_hits | input | 32 | Paddle hits of plane 1 |
| plane2_hits | input | 32 | Paddle hits of plane 2 |
| plane3_hits | input | 32 | Paddle hits of plane 3 |
| trig | output | 1 | Combinational trigger, high when any road matches |
| trig_q | output | 1 | Registered copy of the trigger |
| match_q | output | NUM_ROADS | Registered per-road match vector |

## Verification
The bench builds the block with six roads whose table covers every value of the skipped-plane selector, the edge paddles 0 and 31, and roads in which all three indices differ. With this table the bench can check that every plane pairs with the right index field, and that a missing hit in one plane, a hit on a neighbouring paddle or a hit in the wrong plane leaves a road unmatched. Six roads also make the OR tree uneven, so the padded leaves of the tree are exercised.

// File: rtl/road_pkg.sv
package road_pkg;

    // Detector geometry
    localparam int NUM_PLANES  = 4;
    localparam int NUM_PADDLES = 32;
    localparam int ROAD_PLANES = 3;
    localparam int IDX_W       = $clog2(NUM_PADDLES);
    localparam int SEL_W       = $clog2(NUM_PLANES);
    localparam int ROAD_W      = SEL_W + ROAD_PLANES * IDX_W;

    // Pack one road: skipped plane, then paddles for the remaining planes, ascending.
    function automatic logic [ROAD_W-1:0] road_entry(input int skip, input int lo,
                                                     input int mid, input int hi);
        return {SEL_W'(skip), IDX_W'(lo), IDX_W'(mid), IDX_W'(hi)};
    endfunction

    // Plane used by index slot `slot` (0..2) of a road that skips plane `skip`.
    function automatic int plane_of(input int skip, input int slot);
        return (slot < skip) ? slot : slot + 1;
    endfunction

endpackage

// File: rtl/road_term.sv
module road_term
    import road_pkg::*;
#(
    parameter logic [ROAD_W-1:0] ENTRY = '0
) (
    input  logic [NUM_PLANES-1:0][NUM_PADDLES-1:0] hits_i,
    output logic                                   hit_o
);

    localparam int SKIP = int'(ENTRY[ROAD_W-1 -: SEL_W]);

    logic [ROAD_PLANES-1:0] leg;

    for (genvar s = 0; s < ROAD_PLANES; s++) begin : g_leg
        localparam int IDX   = int'(ENTRY[(ROAD_PLANES-1-s)*IDX_W +: IDX_W]);
        localparam int PLANE = plane_of(SKIP, s);

        if (IDX >= NUM_PADDLES) begin : g_bad_idx
            $error("road_term: paddle index %0d outside 0..%0d", IDX, NUM_PADDLES-1);
        end

        assign leg[s] = hits_i[PLANE][IDX];
    end

    assign hit_o = &leg;

    // Only three bits of the hit bundle are read by any one road.
    logic unused_hits;
    assign unused_hits = ^hits_i;

endmodule

// File: rtl/match_or.sv
module match_or #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] terms_i,
    output logic             any_o
);

    localparam int LEVELS = (WIDTH > 1) ? $clog2(WIDTH) : 0;
    localparam int LEAVES = 1 << LEVELS;
    localparam int NODES  = 2 * LEAVES - 1;

    // Heap layout: node n has children 2n+1 and 2n+2; leaves start at LEAVES-1.
    logic [NODES-1:0] node;

    for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
        if (i < WIDTH) begin : g_live
            assign node[LEAVES-1+i] = terms_i[i];
        end else begin : g_pad
            assign node[LEAVES-1+i] = 1'b0;
        end
    end

    for (genvar n = 0; n < LEAVES - 1; n++) begin : g_inner
        assign node[n] = node[2*n+1] | node[2*n+2];
    end

    assign any_o = node[0];

endmodule

// File: rtl/road_matcher.sv
module road_matcher
    import road_pkg::*;
#(
    parameter int NUM_ROADS = 4,
    parameter logic [NUM_ROADS*ROAD_W-1:0] ROAD_TABLE = {
        road_entry(0, 31, 31, 31),
        road_entry(1, 4, 8, 12),
        road_entry(2, 16, 16, 16),
        road_entry(3, 0, 0, 0)
    }
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [31:0]          plane0_hits,
    input  logic [31:0]          plane1_hits,
    input  logic [31:0]          plane2_hits,
    input  logic [31:0]          plane3_hits,
    output logic                 trig,
    output logic                 trig_q,
    output logic [NUM_ROADS-1:0] match_q
);

    logic [NUM_PLANES-1:0][NUM_PADDLES-1:0] hits;
    logic [NUM_ROADS-1:0]                   road_hit;

    assign hits = {plane3_hits, plane2_hits, plane1_hits, plane0_hits};

    // One AND term per road
    for (genvar r = 0; r < NUM_ROADS; r++) begin : g_road
        road_term #(
            .ENTRY (ROAD_TABLE[r*ROAD_W +: ROAD_W])
        ) u_term (
            .hits_i (hits),
            .hit_o  (road_hit[r])
        );
    end

    // Balanced OR of all road terms
    match_or #(
        .WIDTH (NUM_ROADS)
    ) u_or (
        .terms_i (road_hit),
        .any_o   (trig)
    );

    // Registered copy
    typedef struct packed {
        logic                 trig;
        logic [NUM_ROADS-1:0] match;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d       = out_q;
        out_d.trig  = trig;
        out_d.match = road_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign trig_q  = out_q.trig;
    assign match_q = out_q.match;

endmodule

// File: rtl/road_matcher_chk.sv
module road_matcher_chk #(
    parameter int NUM_ROADS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [31:0]          plane0_hits,
    input logic [31:0]          plane1_hits,
    input logic [31:0]          plane2_hits,
    input logic [31:0]          plane3_hits,
    input logic                 trig,
    input logic                 trig_q,
    input logic [NUM_ROADS-1:0] match_q,
    input logic [NUM_ROADS-1:0] road_hit
);

    // R4: OR tree output agrees with the road terms
    assert_or_tree_R4: assert property (@(posedge clk) disable iff (!rst_n)
        trig == (|road_hit));

    // R4: nothing hit means no trigger
    assert_idle_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((plane0_hits | plane1_hits | plane2_hits | plane3_hits) == 32'd0) |-> !trig);

    // R6: registered trigger follows the combinational one by one edge
    assert_trig_reg_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (trig_q == $past(trig)));

    // R6: registered match vector follows the road terms by one edge
    assert_match_reg_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (match_q == $past(road_hit)));

    // R7: reset holds the registered outputs at zero
    assert_reset_clear_R7: assert property (@(posedge clk)
        !rst_n |-> (!trig_q && (match_q == '0)));

    // R9: registered trigger and match vector agree
    assert_reg_consistent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        trig_q == (|match_q));

endmodule

bind road_matcher road_matcher_chk #(
    .NUM_ROADS (NUM_ROADS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .plane0_hits (plane0_hits),
    .plane1_hits (plane1_hits),
    .plane2_hits (plane2_hits),
    .plane3_hits (plane3_hits),
    .trig        (trig),
    .trig_q      (trig_q),
    .match_q     (match_q),
    .road_hit    (road_hit)
);

// File: tb/sim_road_matcher.sv
`timescale 1ns/1ps
module sim_road_matcher;
    import road_pkg::*;

    localparam int NR = 6;

    // Road k is entry k; the first item in the concatenation is road 5.
    localparam logic [NR*ROAD_W-1:0] TB_ROADS = {
        road_entry(0, 16, 17, 18),   // r5: p1#16 p2#17 p3#18
        road_entry(3, 1, 2, 3),      // r4: p0#1  p1#2  p2#3
        road_entry(2, 7, 8, 9),      // r3: p0#7  p1#8  p3#9
        road_entry(1, 5, 10, 20),    // r2: p0#5  p2#10 p3#20
        road_entry(0, 31, 31, 31),   // r1: p1#31 p2#31 p3#31
        road_entry(3, 0, 0, 0)       // r0: p0#0  p1#0  p2#0
    };

    // {plane0, plane1, plane2, plane3, expected match vector}
    localparam int NV = 12;
    localparam logic [133:0] VEC [NV] = '{
        {32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 6'b000000},
        {32'h0000_0001, 32'h0000_0001, 32'h0000_0001, 32'h0000_0000, 6'b000001},
        {32'h0000_0001, 32'h0000_0001, 32'h0000_0000, 32'h0000_0001, 6'b000000},
        {32'h0000_0000, 32'h8000_0000, 32'h8000_0000, 32'h8000_0000, 6'b000010},
        {32'h0000_0020, 32'h0000_0000, 32'h0000_0400, 32'h0010_0000, 6'b000100},
        {32'h0000_0020, 32'hFFFF_FFFF, 32'h0000_0400, 32'h0010_0000, 6'b000100},
        {32'h0000_0080, 32'h0000_0100, 32'h0000_0000, 32'h0000_0200, 6'b001000},
        {32'h0000_0080, 32'h0000_0100, 32'h0000_0200, 32'h0000_0000, 6'b000000},
        {32'h0000_0002, 32'h0001_0004, 32'h0002_0008, 32'h0004_0000, 6'b110000},
        {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 6'b111111},
        {32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 6'b000100},
        {32'h0000_0042, 32'h0000_0104, 32'h0000_0010, 32'h0000_0200, 6'b000000}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [31:0]   p0 = '0, p1 = '0, p2 = '0, p3 = '0;
    logic          trig, trig_q;
    logic [NR-1:0] match_q;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    road_matcher #(
        .NUM_ROADS  (NR),
        .ROAD_TABLE (TB_ROADS)
    ) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .plane0_hits (p0),
        .plane1_hits (p1),
        .plane2_hits (p2),
        .plane3_hits (p3),
        .trig        (trig),
        .trig_q      (trig_q),
        .match_q     (match_q)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic drive(input logic [133:0] v);
        p0 = v[133:102];
        p1 = v[101:70];
        p2 = v[69:38];
        p3 = v[37:6];
    endtask

    initial begin
        // Reset state with every input hit: registered outputs stay cleared (R7)
        drive({128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 6'b0});
        repeat (3) @(negedge clk);
        check("R7 trig_q held in reset", 32'(trig_q), 32'd0);
        check("R7 match_q held in reset", 32'(match_q), 32'd0);
        check("R5 trig live during reset", 32'(trig), 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R6 first capture after reset", 32'(match_q), 32'h3F);

        // Vector table: R1 R2 R3 R4 R5 R8 R6 R9
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i]);
            #1;
            check($sformatf("R4 R5 R2 trig vec %0d", i), 32'(trig), 32'(VEC[i][5:0] != 0));
            @(negedge clk);
            check($sformatf("R3 R8 R1 R9 match_q vec %0d", i), 32'(match_q), 32'(VEC[i][5:0]));
            check($sformatf("R6 trig_q vec %0d", i), 32'(trig_q), 32'(VEC[i][5:0] != 0));
        end

        // R6: registered outputs hold between edges while inputs change
        @(negedge clk);
        drive(VEC[1]);
        @(negedge clk);
        drive(VEC[0]);
        #2;
        check("R5 trig drops without clock", 32'(trig), 32'd0);
        check("R6 match_q holds until edge", 32'(match_q), 32'h01);

        // R7: asynchronous clear in mid cycle
        @(negedge clk);
        drive(VEC[9]);
        @(negedge clk);
        check("R6 trig_q set before reset", 32'(trig_q), 32'd1);
        #2 rst_n = 1'b0;
        #1;
        check("R7 trig_q cleared without edge", 32'(trig_q), 32'd0);
        check("R7 match_q cleared without edge", 32'(match_q), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 match_q after release", 32'(match_q), 32'h3F);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule